// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block turns a single multiple-register load or store command into a stream of word transfers. A command carries a base address, a register-select mask with one bit per register, an addressing mode and a writeback flag. The block accepts the command, then presents one register index and one word address per cycle on a valid/ready beat interface. When the last beat is taken, it raises a one-cycle completion pulse together with the updated base value.

The mode can be given directly as one of four base modes: increment-after, increment-before, decrement-after and decrement-before. It can also be given as a stack operation, which names a push or a pop on a stack that is full or empty and ascending or descending. The block maps each stack operation onto one of the four base modes. Whatever the mode, lower-numbered registers always land at lower addresses, so the walk always moves upward through memory. The mode only decides where that walk starts and where the base ends up.

The state machine has three states. `ST_IDLE` waits for a command. `ST_RUN` issues beats. `ST_FINISH` produces the completion pulse. Its transitions are:

- idle-to-run: a command with a non-empty mask is accepted.
- idle-to-finish: a command with an empty mask is accepted.
- run-to-run: a beat is accepted and further mask bits remain, or the beat is stalled.
- run-to-finish: the last beat is accepted.
- finish-to-idle: always, one cycle later.

Top module: `xfer_addr_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1, `beat_valid` is 0 and `done` is 0.
- R2: With `cmd_stack`=0, `cmd_mode` selects the base mode: 0 = increment-after, 1 = increment-before, 2 = decrement-after, 3 = decrement-before. With N set mask bits and a word size of 4 bytes, the first beat address is base for mode 0, base+4 for mode 1, base-4N+4 for mode 2 and base-4N for mode 3. Each later beat address is the previous one plus 4.
- R3: One beat is issued per set mask bit. `beat_reg` carries that bit's index, and beats come in strictly ascending index order.
- R4: With `cmd_stack`=1 and `cmd_push`=1, `cmd_mode[1]` means full (1) or empty (0), and `cmd_mode[0]` means ascending (1) or descending (0). The mapping is: full-descending to decrement-before, full-ascending to increment-before, empty-descending to decrement-after, and empty-ascending to increment-after.
- R5: With `cmd_stack`=1 and `cmd_push`=0, using the same field meanings as R4, the mapping is: full-descending to increment-after, full-ascending to decrement-after, empty-descending to increment-before, and empty-ascending to decrement-before.
- R6: While `done` is 1, `new_base` is base+4N for the increment modes and base-4N for the decrement modes when `cmd_wb` was 1. When `cmd_wb` was 0, `new_base` is the unchanged base.
- R7: A command with an all-zero mask produces no beat. `done` rises in the cycle after the command is accepted, and `new_base` equals the base.
- R8: While `beat_valid` is 1 and `beat_ready` is 0, the beat stays valid and `beat_reg` and `beat_addr` hold their values.
- R9: `done` is 1 for exactly one cycle, starting in the cycle after the last beat is accepted. `cmd_ready` is 0 from command acceptance until `done` has been shown.
- R10: Address arithmetic wraps modulo 2^32, both for beat addresses and for `new_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_base | input | 32 | Base address |
| cmd_list | input | 16 | Register-select mask |
| cmd_stack | input | 1 | 1: `cmd_mode` is a stack description |
| cmd_push | input | 1 | Stack operation is a push (1) or a pop (0) |
| cmd_mode | input | 2 | Base mode, or {full, ascending} |
| cmd_wb | input | 1 | Update the base |
| beat_valid | output | 1 | Beat available |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_reg | output | 4 | Register index of the beat |
| beat_addr | output | 32 | Word address of the beat |
| done | output | 1 | One-cycle completion pulse |
| new_base | output | 32 | Final base value, valid with `done` |

## Verification
A corrupted remaining-mask register shows up at the ports on the very next beat. It causes a skipped or repeated register index, an out-of-order index, or a beat count that differs from the mask population, and the bench compares every beat against the mask it sent. A wrong start or step in the address register changes `beat_addr` on the first or the following beat. A wrong mode mapping or span shifts every address of the command by a whole multiple of the word size. A state register stuck in the wrong state is seen within one cycle as a missing or doubled `done`, a beat that appears after `done`, or `cmd_ready` going high while beats are still pending.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    typedef enum logic [1:0] {
        AM_IA = 2'd0,
        AM_IB = 2'd1,
        AM_DA = 2'd2,
        AM_DB = 2'd3
    } addr_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_t;
endpackage

// File: rtl/xfer_mode_map.sv
module xfer_mode_map
    import xfer_pkg::*;
(
    input  logic       use_stack,
    input  logic       push,
    input  logic [1:0] sel,
    output addr_mode_t mode
);
    // sel[1] = full stack, sel[0] = ascending stack when use_stack is set
    always_comb begin
        if (!use_stack) begin
            mode = addr_mode_t'(sel);
        end else begin
            case ({push, sel})
                3'b110:  mode = AM_DB;
                3'b111:  mode = AM_IB;
                3'b100:  mode = AM_DA;
                3'b101:  mode = AM_IA;
                3'b010:  mode = AM_IA;
                3'b011:  mode = AM_DA;
                3'b000:  mode = AM_IB;
                default: mode = AM_DB;
            endcase
        end
    end
endmodule

// File: rtl/xfer_span_calc.sv
module xfer_span_calc
    import xfer_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int WB   = 4
) (
    input  logic [AW-1:0]   base,
    input  logic [NREG-1:0] list,
    input  addr_mode_t      mode,
    output logic [AW-1:0]   start_addr,
    output logic [AW-1:0]   end_base
);
    localparam int CW = $clog2(NREG + 1);

    logic [CW-1:0] cnt;
    logic [AW-1:0] span;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NREG; i++) begin
            cnt = cnt + CW'(list[i]);
        end
    end

    assign span = AW'(cnt) * AW'(WB);

    always_comb begin
        unique case (mode)
            AM_IA: begin
                start_addr = base;
                end_base   = base + span;
            end
            AM_IB: begin
                start_addr = base + AW'(WB);
                end_base   = base + span;
            end
            AM_DA: begin
                start_addr = base - span + AW'(WB);
                end_base   = base - span;
            end
            AM_DB: begin
                start_addr = base - span;
                end_base   = base - span;
            end
        endcase
    end
endmodule

// File: rtl/xfer_pick_low.sv
module xfer_pick_low #(
    parameter int NREG = 16,
    localparam int RIW = $clog2(NREG)
) (
    input  logic [NREG-1:0] list,
    output logic [RIW-1:0]  idx,
    output logic [NREG-1:0] rest
);
    always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (list[i]) idx = RIW'(i);
        end
    end

    // clear the lowest set bit
    assign rest = list & (list - NREG'(1));
endmodule

// File: rtl/xfer_addr_seq.sv
module xfer_addr_seq
    import xfer_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int WB   = 4,
    localparam int RIW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [AW-1:0]   cmd_base,
    input  logic [NREG-1:0] cmd_list,
    input  logic            cmd_stack,
    input  logic            cmd_push,
    input  logic [1:0]      cmd_mode,
    input  logic            cmd_wb,
    output logic            beat_valid,
    input  logic            beat_ready,
    output logic [RIW-1:0]  beat_reg,
    output logic [AW-1:0]   beat_addr,
    output logic            done,
    output logic [AW-1:0]   new_base
);
    seq_state_t      state, nxt;
    addr_mode_t      mode;
    logic [AW-1:0]   start_addr, end_base;
    logic [NREG-1:0] rem_list, rem_next;
    logic [AW-1:0]   cur_addr, fin_base;
    logic            take_cmd, take_beat;

    xfer_mode_map u_map (
        .use_stack(cmd_stack),
        .push     (cmd_push),
        .sel      (cmd_mode),
        .mode     (mode)
    );

    xfer_span_calc #(.NREG(NREG), .AW(AW), .WB(WB)) u_span (
        .base      (cmd_base),
        .list      (cmd_list),
        .mode      (mode),
        .start_addr(start_addr),
        .end_base  (end_base)
    );

    xfer_pick_low #(.NREG(NREG)) u_pick (
        .list(rem_list),
        .idx (beat_reg),
        .rest(rem_next)
    );

    assign take_cmd  = cmd_valid && cmd_ready;
    assign take_beat = beat_valid && beat_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (take_cmd) nxt = (cmd_list == '0) ? ST_FINISH : ST_RUN;
            end
            ST_RUN: begin
                if (take_beat && rem_next == '0) nxt = ST_FINISH;
            end
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_list <= '0;
            cur_addr <= '0;
            fin_base <= '0;
        end else if (take_cmd) begin
            rem_list <= cmd_list;
            cur_addr <= start_addr;
            fin_base <= cmd_wb ? end_base : cmd_base;
        end else if (take_beat) begin
            rem_list <= rem_next;
            cur_addr <= cur_addr + AW'(WB);
        end
    end

    always_comb begin
        cmd_ready  = 1'b0;
        beat_valid = 1'b0;
        done       = 1'b0;
        unique case (state)
            ST_IDLE:   cmd_ready  = 1'b1;
            ST_RUN:    beat_valid = 1'b1;
            ST_FINISH: done       = 1'b1;
            default:   cmd_ready  = 1'b0;
        endcase
    end

    assign beat_addr = cur_addr;
    assign new_base  = fin_base;
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int WB   = 4,
    localparam int RIW = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic [NREG-1:0] cmd_list,
    input logic            beat_valid,
    input logic            beat_ready,
    input logic [RIW-1:0]  beat_reg,
    input logic [AW-1:0]   beat_addr,
    input logic            done
);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) && $stable(beat_reg));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready |=> !beat_valid || beat_addr == $past(beat_addr) + AW'(WB));

    assert_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready |=> !beat_valid || beat_reg > $past(beat_reg));

    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !cmd_ready && !done);

    assert_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_list == '0 |=> done && !beat_valid);
endmodule

bind xfer_addr_seq xfer_seq_chk #(.NREG(NREG), .AW(AW), .WB(WB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_list  (cmd_list),
    .beat_valid(beat_valid),
    .beat_ready(beat_ready),
    .beat_reg  (beat_reg),
    .beat_addr (beat_addr),
    .done      (done)
);

// File: tb/sim_xfer_addr_seq.sv
module sim_xfer_addr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_base = '0;
    logic [15:0] cmd_list = '0;
    logic        cmd_stack = 1'b0;
    logic        cmd_push = 1'b0;
    logic [1:0]  cmd_mode = '0;
    logic        cmd_wb = 1'b0;
    logic        beat_valid;
    logic        beat_ready = 1'b1;
    logic [3:0]  beat_reg;
    logic [31:0] beat_addr;
    logic        done;
    logic [31:0] new_base;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    xfer_addr_seq u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_base(cmd_base), .cmd_list(cmd_list),
        .cmd_stack(cmd_stack), .cmd_push(cmd_push),
        .cmd_mode(cmd_mode), .cmd_wb(cmd_wb),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_reg(beat_reg), .beat_addr(beat_addr),
        .done(done), .new_base(new_base)
    );

    typedef struct packed {
        logic        stk;
        logic        psh;
        logic [1:0]  md;
        logic        wb;
        logic [31:0] base;
        logic [15:0] list;
        logic [31:0] first;
        logic [31:0] fin;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 2'd0, 1'b1, 32'h1000, 16'h0013, 32'h1000, 32'h100C},
        '{1'b0, 1'b0, 2'd1, 1'b1, 32'h1000, 16'h8001, 32'h1004, 32'h1008},
        '{1'b0, 1'b0, 2'd2, 1'b1, 32'h1000, 16'h00F0, 32'h0FF4, 32'h0FF0},
        '{1'b0, 1'b0, 2'd3, 1'b0, 32'h1000, 16'h0005, 32'h0FF8, 32'h1000},
        '{1'b1, 1'b1, 2'd2, 1'b1, 32'h1000, 16'h4010, 32'h0FF8, 32'h0FF8},
        '{1'b1, 1'b1, 2'd3, 1'b1, 32'h1000, 16'h0001, 32'h1004, 32'h1004},
        '{1'b1, 1'b1, 2'd0, 1'b1, 32'h1000, 16'h0007, 32'h0FF8, 32'h0FF4},
        '{1'b1, 1'b1, 2'd1, 1'b1, 32'h1000, 16'h0300, 32'h1000, 32'h1008},
        '{1'b1, 1'b0, 2'd2, 1'b1, 32'h1000, 16'h0011, 32'h1000, 32'h1008},
        '{1'b1, 1'b0, 2'd3, 1'b1, 32'h1000, 16'h0003, 32'h0FFC, 32'h0FF8},
        '{1'b1, 1'b0, 2'd0, 1'b1, 32'h1000, 16'h0101, 32'h1004, 32'h1008},
        '{1'b1, 1'b0, 2'd1, 1'b1, 32'h1000, 16'hFFFF, 32'h0FC0, 32'h0FC0},
        '{1'b0, 1'b0, 2'd3, 1'b1, 32'h0000_0004, 16'h0003, 32'hFFFF_FFFC, 32'hFFFF_FFFC},
        '{1'b0, 1'b0, 2'd0, 1'b1, 32'hFFFF_FFF8, 16'h0007, 32'hFFFF_FFF8, 32'h0000_0004}
    };

    function automatic string vec_tag(input int i);
        if (i < 4)  return "R2";
        if (i < 8)  return "R4";
        if (i < 12) return "R5";
        return "R10";
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            report();
        end
    end

    task automatic issue(input logic stk, input logic psh, input logic [1:0] md,
                         input logic wb, input logic [31:0] base, input logic [15:0] list);
        @(negedge clk);
        cmd_stack = stk;
        cmd_push  = psh;
        cmd_mode  = md;
        cmd_wb    = wb;
        cmd_base  = base;
        cmd_list  = list;
        cmd_valid = 1'b1;
        chk(cmd_ready == 1'b1, "R9", 32'(cmd_ready), 32'd1);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // called at the negedge right after command acceptance
    task automatic collect(input logic [15:0] list, input logic [31:0] first,
                           input logic [31:0] fin, input bit bp, input string tag);
        int          k = 0;
        int          nexp = 0;
        int          ridx = -1;
        int          cyc = 0;
        int          e;
        logic [31:0] ea = first;
        bit          last_acc = 0;
        bit          hold = 0;
        logic [31:0] h_addr = '0;
        logic [3:0]  h_reg = '0;
        for (int j = 0; j < 16; j++) nexp += int'(list[j]);
        while (1) begin
            if (done) begin
                chk(last_acc || nexp == 0, "R9", 32'(k), 32'(nexp));
                chk(k == nexp, "R3", 32'(k), 32'(nexp));
                chk(new_base == fin, "R6", new_base, fin);
                break;
            end else if (last_acc) begin
                chk(1'b0, "R9", 32'(done), 32'd1);
                break;
            end
            if (hold) begin
                chk(beat_valid && beat_addr == h_addr && beat_reg == h_reg, "R8", beat_addr, h_addr);
            end
            beat_ready = bp ? (cyc % 3 != 1) : 1'b1;
            if (beat_valid) begin
                chk(cmd_ready == 1'b0, "R9", 32'(cmd_ready), 32'd0);
                e = -1;
                for (int j = ridx + 1; j < 16; j++) begin
                    if (list[j]) begin
                        e = j;
                        break;
                    end
                end
                chk(int'(beat_reg) == e, "R3", 32'(beat_reg), 32'(e));
                chk(beat_addr == ea, tag, beat_addr, ea);
                if (beat_ready) begin
                    k++;
                    ea = ea + 32'd4;
                    ridx = e;
                    last_acc = (k == nexp);
                    hold = 0;
                end else begin
                    hold = 1;
                    h_addr = beat_addr;
                    h_reg = beat_reg;
                end
            end
            @(negedge clk);
            cyc++;
            if (cyc > 200) begin
                chk(1'b0, "R9", 32'(cyc), 32'd200);
                break;
            end
        end
        beat_ready = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R9", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", 32'(cmd_ready), 32'd1);
        chk(beat_valid == 1'b0, "R1", 32'(beat_valid), 32'd0);
        chk(done == 1'b0, "R1", 32'(done), 32'd0);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].stk, VEC[i].psh, VEC[i].md, VEC[i].wb, VEC[i].base, VEC[i].list);
            collect(VEC[i].list, VEC[i].first, VEC[i].fin, 1'b0, vec_tag(i));
        end

        // R8: stalls on the consumer side, decrement-after with a sparse mask
        issue(1'b0, 1'b0, 2'd2, 1'b1, 32'h2000, 16'hA5A5);
        collect(16'hA5A5, 32'h2000 - 32'd32 + 32'd4, 32'h2000 - 32'd32, 1'b1, "R2");

        // R7: empty mask with writeback requested
        issue(1'b0, 1'b0, 2'd3, 1'b1, 32'h3000, 16'h0000);
        chk(done == 1'b1, "R7", 32'(done), 32'd1);
        chk(beat_valid == 1'b0, "R7", 32'(beat_valid), 32'd0);
        chk(new_base == 32'h3000, "R7", new_base, 32'h3000);
        @(negedge clk);
        chk(done == 1'b0, "R7", 32'(done), 32'd0);
        chk(cmd_ready == 1'b1, "R9", 32'(cmd_ready), 32'd1);

        // R6: single register, increment-before, writeback off
        issue(1'b0, 1'b0, 2'd1, 1'b0, 32'h4000, 16'h8000);
        collect(16'h8000, 32'h4004, 32'h4000, 1'b0, "R2");

        // R1: reset in the middle of a transfer
        issue(1'b0, 1'b0, 2'd0, 1'b1, 32'h5000, 16'hFFFF);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b1 && beat_valid == 1'b0 && done == 1'b0, "R1",
            {29'd0, cmd_ready, beat_valid, done}, 32'd4);

        report();
    end
endmodule